// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Write Output Modes

Two fully independent ports, A and B, share one storage array. Each port has its own clock, enable, write enable, synchronous output set/reset, address, data input with parity bits and a registered data output with parity bits. Any port can read or write any word. A parameter on each port fixes what its output register shows in a cycle where that port writes. In write-first mode it shows the new word. In read-first mode it shows the word that was overwritten. In no-change mode it keeps its previous value.

The set/reset input loads a port's output register with that port's init value and leaves the stored words alone. The total word width includes the parity bits. At the default of 36 bits, the top 4 bits travel on the parity buses and are stored and returned without any check. Port B knows when port A writes the same word on the same edge, and in that case port B's write is dropped, so port A's data is kept.

Top module: `dpram_wmode`

## Requirements
- R1: With enable high, write enable low and set/reset low, the port's output after the clock edge equals the stored word at the addressed location.
- R2: A port with MODE = 0 (write-first) that writes with set/reset low shows the written word on its output after that edge.
- R3: A port with MODE = 1 (read-first) that writes with set/reset low shows the word stored before the write, and the new word is stored.
- R4: A port with MODE = 2 (no-change) keeps its output unchanged across any edge at which it writes with set/reset low.
- R5: With enable low, a port stores nothing, keeps its output unchanged and ignores set/reset.
- R6: Set/reset with enable high loads the port's SRVAL into its output register, taking priority over the mode-based update. A write in the same cycle is still stored.
- R7: Set/reset on one port changes neither the stored words nor the other port's output.
- R8: The word is WIDTH bits wide with WIDTH in {1,2,4,9,18,36}. The parity count is 4, 2 or 1 for widths 36, 18 or 9, and 0 otherwise. The parity bits are the top bits of the word, appear on the parity buses, and are stored and returned unchanged.
- R9: When both ports write the same address at the same edge, the stored word is port A's data.
- R10: Each output register holds its port's SRVAL from time zero until its first enabled update.
- R11: A word written through either port can be read through the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| ssr_a | input | 1 | Port A synchronous output set/reset |
| addr_a | input | AW | Port A word address |
| din_a | input | DW | Port A write data |
| dinp_a | input | PWX | Port A write parity |
| dout_a | output | DW | Port A read data |
| doutp_a | output | PWX | Port A read parity |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| ssr_b | input | 1 | Port B synchronous output set/reset |
| addr_b | input | AW | Port B word address |
| din_b | input | DW | Port B write data |
| dinp_b | input | PWX | Port B write parity |
| dout_b | output | DW | Port B read data |
| doutp_b | output | PWX | Port B read parity |

## Verification
The hardest case to reach is a word that is written by both ports on one edge and then read back. Random traffic on a small address set almost never lines this up with a later read, and it never checks which copy of the word the read uses. A directed step therefore issues the colliding writes and then reads the word through both ports. Random traffic uses only 16 addresses, so reads on one port often follow writes from the other, and the cross-port path is exercised in all three output modes. Two instances with different mode settings run on the same stimulus, so every mode sees the same write, set/reset and disable patterns.

// File: rtl/dpram_wmode.sv
module dpram_wmode #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 512,
  parameter int MODE_A = 0,
  parameter int MODE_B = 0,
  parameter logic [WIDTH-1:0] SRVAL_A = '0,
  parameter logic [WIDTH-1:0] SRVAL_B = '0,
  localparam int PW  = (WIDTH == 36) ? 4 : (WIDTH == 18) ? 2 : (WIDTH == 9) ? 1 : 0,
  localparam int PWX = (PW > 0) ? PW : 1,
  localparam int DW  = WIDTH - PW,
  localparam int AW  = $clog2(DEPTH)
) (
  input  logic           clk_a,
  input  logic           en_a,
  input  logic           we_a,
  input  logic           ssr_a,
  input  logic [AW-1:0]  addr_a,
  input  logic [DW-1:0]  din_a,
  input  logic [PWX-1:0] dinp_a,
  output logic [DW-1:0]  dout_a,
  output logic [PWX-1:0] doutp_a,
  input  logic           clk_b,
  input  logic           en_b,
  input  logic           we_b,
  input  logic           ssr_b,
  input  logic [AW-1:0]  addr_b,
  input  logic [DW-1:0]  din_b,
  input  logic [PWX-1:0] dinp_b,
  output logic [DW-1:0]  dout_b,
  output logic [PWX-1:0] doutp_b
);
  // Each port writes only its own bank; per-word tags say which bank is newer.
  logic [WIDTH-1:0] bank_a [DEPTH];
  logic [WIDTH-1:0] bank_b [DEPTH];
  logic             tag_a  [DEPTH];
  logic             tag_b  [DEPTH];

  logic [WIDTH-1:0] q_a = SRVAL_A;
  logic [WIDTH-1:0] q_b = SRVAL_B;
  logic [WIDTH-1:0] wd_a, wd_b, rd_a, rd_b;
  logic             hit_ab;

  generate
    if (PW > 0) begin : g_par
      assign wd_a    = {dinp_a, din_a};
      assign wd_b    = {dinp_b, din_b};
      assign doutp_a = q_a[WIDTH-1:DW];
      assign doutp_b = q_b[WIDTH-1:DW];
    end else begin : g_nopar
      assign wd_a    = din_a;
      assign wd_b    = din_b;
      assign doutp_a = '0;
      assign doutp_b = '0;
    end
  endgenerate

  assign dout_a = q_a[DW-1:0];
  assign dout_b = q_b[DW-1:0];
  assign rd_a   = (tag_a[addr_a] == tag_b[addr_a]) ? bank_a[addr_a] : bank_b[addr_a];
  assign rd_b   = (tag_a[addr_b] == tag_b[addr_b]) ? bank_a[addr_b] : bank_b[addr_b];
  assign hit_ab = en_a && we_a && (addr_a == addr_b);

  always_ff @(posedge clk_a) begin
    if (en_a) begin
      if (we_a) begin
        bank_a[addr_a] <= wd_a;
        tag_a[addr_a]  <= tag_b[addr_a];
      end
      if (ssr_a)                     q_a <= SRVAL_A;
      else if (!we_a || MODE_A == 1) q_a <= rd_a;
      else if (MODE_A == 0)          q_a <= wd_a;
    end
  end

  always_ff @(posedge clk_b) begin
    if (en_b) begin
      if (we_b && !hit_ab) begin
        bank_b[addr_b] <= wd_b;
        tag_b[addr_b]  <= !tag_a[addr_b];
      end
      if (ssr_b)                     q_b <= SRVAL_B;
      else if (!we_b || MODE_B == 1) q_b <= rd_b;
      else if (MODE_B == 0)          q_b <= wd_b;
    end
  end

  logic seen_a = 1'b0;
  logic seen_b = 1'b0;
  always_ff @(posedge clk_a) seen_a <= 1'b1;
  always_ff @(posedge clk_b) seen_b <= 1'b1;

  assert_wf_a_R2: assert property (@(posedge clk_a) disable iff (!seen_a)
    (MODE_A == 0 && en_a && we_a && !ssr_a) |=> (q_a == $past(wd_a)));
  assert_wf_b_R2: assert property (@(posedge clk_b) disable iff (!seen_b)
    (MODE_B == 0 && en_b && we_b && !ssr_b) |=> (q_b == $past(wd_b)));
  assert_nc_a_R4: assert property (@(posedge clk_a) disable iff (!seen_a)
    (MODE_A == 2 && en_a && we_a && !ssr_a) |=> $stable(q_a));
  assert_nc_b_R4: assert property (@(posedge clk_b) disable iff (!seen_b)
    (MODE_B == 2 && en_b && we_b && !ssr_b) |=> $stable(q_b));
  assert_idle_a_R5: assert property (@(posedge clk_a) disable iff (!seen_a)
    !en_a |=> $stable(q_a));
  assert_idle_b_R5: assert property (@(posedge clk_b) disable iff (!seen_b)
    !en_b |=> $stable(q_b));
  assert_sr_a_R6: assert property (@(posedge clk_a) disable iff (!seen_a)
    (en_a && ssr_a) |=> (q_a == SRVAL_A));
  assert_sr_b_R6: assert property (@(posedge clk_b) disable iff (!seen_b)
    (en_b && ssr_b) |=> (q_b == SRVAL_B));
endmodule

// File: tb/test_dpram_wmode.sv
module test_dpram_wmode;
  localparam logic [35:0] SA = 36'h0A5A5A5A5;
  localparam logic [35:0] SB = 36'h123456789;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic en_a = 0, we_a = 0, ssr_a = 0, en_b = 0, we_b = 0, ssr_b = 0;
  logic [8:0]  addr_a = '0, addr_b = '0;
  logic [35:0] wa = '0, wb = '0;
  logic [31:0] d_a0, d_b0, d_a1, d_b1;
  logic [3:0]  p_a0, p_b0, p_a1, p_b1;

  logic [35:0] mdl [512];
  logic [35:0] e_a0 = SA, e_b0 = SB, e_a1 = SA, e_b1 = SB;
  int vectors = 0, fails = 0;

  // instance 0: A write-first, B read-first; instance 1: both no-change
  dpram_wmode #(.MODE_A(0), .MODE_B(1), .SRVAL_A(SA), .SRVAL_B(SB)) i_dpram_wmode (
    .clk_a(clk), .en_a(en_a), .we_a(we_a), .ssr_a(ssr_a), .addr_a(addr_a),
    .din_a(wa[31:0]), .dinp_a(wa[35:32]), .dout_a(d_a0), .doutp_a(p_a0),
    .clk_b(clk), .en_b(en_b), .we_b(we_b), .ssr_b(ssr_b), .addr_b(addr_b),
    .din_b(wb[31:0]), .dinp_b(wb[35:32]), .dout_b(d_b0), .doutp_b(p_b0));

  dpram_wmode #(.MODE_A(2), .MODE_B(2), .SRVAL_A(SA), .SRVAL_B(SB)) i_dpram_wmode_nc (
    .clk_a(clk), .en_a(en_a), .we_a(we_a), .ssr_a(ssr_a), .addr_a(addr_a),
    .din_a(wa[31:0]), .dinp_a(wa[35:32]), .dout_a(d_a1), .doutp_a(p_a1),
    .clk_b(clk), .en_b(en_b), .we_b(we_b), .ssr_b(ssr_b), .addr_b(addr_b),
    .din_b(wb[31:0]), .dinp_b(wb[35:32]), .dout_b(d_b1), .doutp_b(p_b1));

  function automatic logic [35:0] nxt(int mode, logic en, logic we, logic ssr,
                                      logic [35:0] cur, logic [35:0] sv,
                                      logic [35:0] wd, logic [35:0] old);
    if (!en) return cur;
    if (ssr) return sv;
    if (!we || mode == 1) return old;
    if (mode == 0) return wd;
    return cur;
  endfunction

  function automatic string rtag(int mode, logic en, logic we, logic ssr);
    if (!en) return "R5";
    if (ssr) return "R6";
    if (!we) return "R1";
    return (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4";
  endfunction

  task automatic chk(string r, logic [35:0] act, logic [35:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic apply(string lbl);
    logic [35:0] oa, ob;
    string ta0, tb0, ta1, tb1;
    oa = mdl[addr_a];
    ob = mdl[addr_b];
    ta0 = (lbl != "") ? lbl : rtag(0, en_a, we_a, ssr_a);
    tb0 = (lbl != "") ? lbl : rtag(1, en_b, we_b, ssr_b);
    ta1 = (lbl != "") ? lbl : rtag(2, en_a, we_a, ssr_a);
    tb1 = (lbl != "") ? lbl : rtag(2, en_b, we_b, ssr_b);
    e_a0 = nxt(0, en_a, we_a, ssr_a, e_a0, SA, wa, oa);
    e_b0 = nxt(1, en_b, we_b, ssr_b, e_b0, SB, wb, ob);
    e_a1 = nxt(2, en_a, we_a, ssr_a, e_a1, SA, wa, oa);
    e_b1 = nxt(2, en_b, we_b, ssr_b, e_b1, SB, wb, ob);
    if (en_b && we_b) mdl[addr_b] = wb;
    if (en_a && we_a) mdl[addr_a] = wa;  // R9: port A wins a same-address collision
    @(posedge clk);
    #1;
    chk(ta0, {p_a0, d_a0}, e_a0);
    chk(tb0, {p_b0, d_b0}, e_b0);
    chk(ta1, {p_a1, d_a1}, e_a1);
    chk(tb1, {p_b1, d_b1}, e_b1);
  endtask

  task automatic drv(logic ea, logic wea, logic sa, logic [8:0] aa, logic [35:0] da,
                     logic eb, logic web, logic sb, logic [8:0] ab, logic [35:0] db);
    en_a = ea; we_a = wea; ssr_a = sa; addr_a = aa; wa = da;
    en_b = eb; we_b = web; ssr_b = sb; addr_b = ab; wb = db;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    #1;
    chk("R10", {p_a0, d_a0}, SA);
    chk("R10", {p_b0, d_b0}, SB);
    chk("R10", {p_a1, d_a1}, SA);
    chk("R10", {p_b1, d_b1}, SB);
    for (int i = 0; i < 24; i++) begin
      drv(1, 1, 0, 9'(i), {4'(i), 32'h1000 + 32'(i)}, 0, 0, 0, 0, 0);
      apply("");
    end
    // R11: write through A, read through B
    drv(1, 1, 0, 9'd30, 36'h9DEADBEEF, 0, 0, 0, 0, 0); apply("R11");
    drv(0, 0, 0, 0, 0, 1, 0, 0, 9'd30, 0);             apply("R11");
    // R8: parity bits written through B come back on A's parity bus
    drv(0, 0, 0, 0, 0, 1, 1, 0, 9'd31, 36'hC01234567); apply("R8");
    drv(1, 0, 0, 9'd31, 0, 0, 0, 0, 0, 0);             apply("R8");
    // R6: set/reset with a write on A still stores; R7: B output unaffected
    drv(1, 1, 1, 9'd32, 36'h355AA55AA, 1, 0, 0, 9'd31, 0); apply("R7");
    drv(1, 0, 0, 9'd32, 0, 1, 0, 0, 9'd31, 0);             apply("R6");
    drv(1, 0, 1, 9'd31, 0, 1, 0, 0, 9'd32, 0);             apply("R7");
    drv(1, 0, 0, 9'd31, 0, 1, 0, 0, 9'd32, 0);             apply("R7");
    // R5: disabled A ignores write and set/reset
    drv(0, 1, 1, 9'd31, 36'hFFFFFFFFF, 0, 0, 0, 0, 0);    apply("R5");
    drv(1, 0, 0, 9'd31, 0, 0, 0, 0, 0, 0);                apply("R5");
    // R9: same-address collision, then read back through both ports
    drv(1, 1, 0, 9'd33, 36'h1AAAA0001, 1, 1, 0, 9'd33, 36'h2BBBB0002); apply("R9");
    drv(1, 0, 0, 9'd33, 0, 1, 0, 0, 9'd33, 0);                         apply("R9");
    // write-mode outputs on each port with a known old value
    drv(1, 1, 0, 9'd1, 36'h711111111, 1, 1, 0, 9'd2, 36'h822222222); apply("");
    for (int n = 0; n < 3000; n++) begin
      logic [8:0] aa, ab;
      logic wea, web;
      aa = 9'($urandom_range(0, 15));
      ab = 9'($urandom_range(0, 15));
      wea = 1'($urandom);
      web = 1'($urandom);
      if (wea && web && aa == ab) web = 1'b0;
      drv(($urandom_range(0, 7) != 0), wea, ($urandom_range(0, 9) == 0), aa, {4'($urandom), 32'($urandom)},
          ($urandom_range(0, 7) != 0), web, ($urandom_range(0, 9) == 0), ab, {4'($urandom), 32'($urandom)});
      apply("");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule